// File: doc/BRIEF.md
# Bank and Mirroring Address Translator

This block is the address-translation half of a cartridge memory mapper. It takes the processor's 15-bit program-space address, the video unit's 13-bit tile-pattern address and a 12-bit nametable address. It turns each one into a physical address, either into a large program ROM, a tile ROM, or a 2 KB nametable RAM. It also produces the enable for the cartridge work RAM.

The translation is steered by configuration fields that a separate serial register block loads. These fields are the program window size and fixed-bank choice, the program bank number, the tile split mode, the two tile bank numbers, the nametable mirroring mode and the work-RAM block flag. The translator holds no state. Every output follows its inputs within the same cycle, so it can sit directly in the memory access path of both buses.

Program ROM is addressed as 16 KB pages and tile ROM as 4 KB pages. The nametable RAM is addressed as two 1 KB pages.

Top module: `bank_xlate`

## Requirements
- R1: `prog_addr_o[13:0]` always equals `cpu_addr_i[13:0]`. The page number appears in `prog_addr_o[17:14]`, and `cpu_addr_i[14]` is the program region (0 = lower half, 1 = upper half).
- R2: With `prog_win16_i` = 0 (32 KB mode), the page is `prog_bank_i` with bit 0 replaced by the region bit.
- R3: With `prog_win16_i` = 1 and `prog_fix_last_i` = 1, region 0 uses page `prog_bank_i` and region 1 is fixed to the last page (all ones, 15).
- R4: With `prog_win16_i` = 1 and `prog_fix_last_i` = 0, region 0 is fixed to page 0 and region 1 uses page `prog_bank_i`.
- R5: `tile_addr_o[11:0]` always equals `tile_addr_i[11:0]`. The page appears in `tile_addr_o[16:12]`, and `tile_addr_i[12]` is the tile region.
- R6: With `tile_split_i` = 1, region 0 uses `tile_bank0_i` and region 1 uses `tile_bank1_i`.
- R7: With `tile_split_i` = 0, both regions use `tile_bank0_i` with bit 0 replaced by the tile region bit. `tile_bank1_i` has no effect.
- R8: `nt_mode_i` = 0 places every access in page 0 (`nt_addr_o[10]` = 0), and `nt_mode_i` = 1 places it in page 1 (`nt_addr_o[10]` = 1).
- R9: `nt_mode_i` = 2 takes the page from `nt_addr_i[10]`, and `nt_mode_i` = 3 takes it from `nt_addr_i[11]`. `nt_addr_o[9:0]` always equals `nt_addr_i[9:0]` in every mode.
- R10: `wram_en_o` is 0 while `wram_block_i` is 1, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_addr_i | input | 15 | Processor program-space address |
| tile_addr_i | input | 13 | Video pattern-table address |
| nt_addr_i | input | 12 | Video nametable address |
| prog_win16_i | input | 1 | 1 = 16 KB program windows, 0 = one 32 KB window |
| prog_fix_last_i | input | 1 | In 16 KB mode: 1 = upper region fixed to last page, 0 = lower region fixed to page 0 |
| prog_bank_i | input | 4 | Program page number |
| tile_split_i | input | 1 | 1 = two independent 4 KB tile pages, 0 = one 8 KB pair |
| tile_bank0_i | input | 5 | Tile page for region 0 (or pair base) |
| tile_bank1_i | input | 5 | Tile page for region 1 |
| nt_mode_i | input | 2 | Mirroring: 0 page 0, 1 page 1, 2 by bit 10, 3 by bit 11 |
| wram_block_i | input | 1 | Work-RAM block flag |
| prog_addr_o | output | 18 | Physical program ROM address |
| tile_addr_o | output | 17 | Physical tile ROM address |
| nt_addr_o | output | 11 | Nametable RAM address |
| wram_en_o | output | 1 | Work-RAM enable |

## Verification
The bound checker watches the invariant parts of the translation on every input change. These are the offset bits that pass through on all three paths, and the program region bit in 32 KB mode. They also include both fixed program pages, the tile region bit in paired mode, the fixed nametable pages and the work-RAM enable. The exact switchable page numbers depend on mode, region and bank inputs together, and only the bench's reference model compares them value by value. Two cases can only be seen from the bench's scenarios: that `tile_bank1_i` is ignored in paired mode, and that the `prog_bank_i` low bit is dropped in 32 KB mode.

// File: rtl/bank_xlate_pkg.sv
package bank_xlate_pkg;

  localparam int unsigned PROG_PAGE_BITS = 14;
  localparam int unsigned TILE_PAGE_BITS = 12;
  localparam int unsigned NT_PAGE_BITS   = 10;

  typedef enum logic [1:0] {
    NT_PAGE_LOW  = 2'd0,
    NT_PAGE_HIGH = 2'd1,
    NT_BY_BIT10  = 2'd2,
    NT_BY_BIT11  = 2'd3
  } nt_mode_e;

endpackage

// File: rtl/bank_xlate_prog.sv
module bank_xlate_prog
  import bank_xlate_pkg::*;
#(
  parameter int unsigned BANK_W = 4,
  localparam int unsigned IN_W  = PROG_PAGE_BITS + 1,
  localparam int unsigned OUT_W = PROG_PAGE_BITS + BANK_W
) (
  input  logic [IN_W-1:0]   addr_i,
  input  logic              win16_i,
  input  logic              fix_last_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic [OUT_W-1:0]  addr_o
);

  logic              region;
  logic [BANK_W-1:0] page;

  assign region = addr_i[PROG_PAGE_BITS];

  always_comb begin
    if (!win16_i) begin
      page = {bank_i[BANK_W-1:1], region};
    end else if (region == fix_last_i) begin
      page = {BANK_W{region}};
    end else begin
      page = bank_i;
    end
  end

  assign addr_o = {page, addr_i[PROG_PAGE_BITS-1:0]};

endmodule

// File: rtl/bank_xlate_tile.sv
module bank_xlate_tile
  import bank_xlate_pkg::*;
#(
  parameter int unsigned BANK_W = 5,
  localparam int unsigned IN_W  = TILE_PAGE_BITS + 1,
  localparam int unsigned OUT_W = TILE_PAGE_BITS + BANK_W
) (
  input  logic [IN_W-1:0]   addr_i,
  input  logic              split_i,
  input  logic [BANK_W-1:0] bank0_i,
  input  logic [BANK_W-1:0] bank1_i,
  output logic [OUT_W-1:0]  addr_o
);

  logic              region;
  logic [BANK_W-1:0] page;

  assign region = addr_i[TILE_PAGE_BITS];

  always_comb begin
    if (split_i) begin
      page = region ? bank1_i : bank0_i;
    end else begin
      page = {bank0_i[BANK_W-1:1], region};
    end
  end

  assign addr_o = {page, addr_i[TILE_PAGE_BITS-1:0]};

endmodule

// File: rtl/bank_xlate_nt.sv
module bank_xlate_nt
  import bank_xlate_pkg::*;
#(
  localparam int unsigned IN_W  = NT_PAGE_BITS + 2,
  localparam int unsigned OUT_W = NT_PAGE_BITS + 1
) (
  input  logic [IN_W-1:0]  addr_i,
  input  logic [1:0]       mode_i,
  output logic [OUT_W-1:0] addr_o
);

  nt_mode_e mode;
  logic     page;

  assign mode = nt_mode_e'(mode_i);

  always_comb begin
    unique case (mode)
      NT_PAGE_LOW:  page = 1'b0;
      NT_PAGE_HIGH: page = 1'b1;
      NT_BY_BIT10:  page = addr_i[NT_PAGE_BITS];
      NT_BY_BIT11:  page = addr_i[NT_PAGE_BITS+1];
      default:      page = 1'b0;
    endcase
  end

  assign addr_o = {page, addr_i[NT_PAGE_BITS-1:0]};

endmodule

// File: rtl/bank_xlate.sv
module bank_xlate
  import bank_xlate_pkg::*;
#(
  parameter int unsigned PROG_BANK_W = 4,
  parameter int unsigned TILE_BANK_W = 5,
  localparam int unsigned CPU_W   = PROG_PAGE_BITS + 1,
  localparam int unsigned TILE_W  = TILE_PAGE_BITS + 1,
  localparam int unsigned NT_W    = NT_PAGE_BITS + 2,
  localparam int unsigned PROG_OW = PROG_PAGE_BITS + PROG_BANK_W,
  localparam int unsigned TILE_OW = TILE_PAGE_BITS + TILE_BANK_W,
  localparam int unsigned NT_OW   = NT_PAGE_BITS + 1
) (
  input  logic [CPU_W-1:0]       cpu_addr_i,
  input  logic [TILE_W-1:0]      tile_addr_i,
  input  logic [NT_W-1:0]        nt_addr_i,
  input  logic                   prog_win16_i,
  input  logic                   prog_fix_last_i,
  input  logic [PROG_BANK_W-1:0] prog_bank_i,
  input  logic                   tile_split_i,
  input  logic [TILE_BANK_W-1:0] tile_bank0_i,
  input  logic [TILE_BANK_W-1:0] tile_bank1_i,
  input  logic [1:0]             nt_mode_i,
  input  logic                   wram_block_i,
  output logic [PROG_OW-1:0]     prog_addr_o,
  output logic [TILE_OW-1:0]     tile_addr_o,
  output logic [NT_OW-1:0]       nt_addr_o,
  output logic                   wram_en_o
);

  bank_xlate_prog #(.BANK_W(PROG_BANK_W)) u_prog (
    .addr_i     (cpu_addr_i),
    .win16_i    (prog_win16_i),
    .fix_last_i (prog_fix_last_i),
    .bank_i     (prog_bank_i),
    .addr_o     (prog_addr_o)
  );

  bank_xlate_tile #(.BANK_W(TILE_BANK_W)) u_tile (
    .addr_i  (tile_addr_i),
    .split_i (tile_split_i),
    .bank0_i (tile_bank0_i),
    .bank1_i (tile_bank1_i),
    .addr_o  (tile_addr_o)
  );

  bank_xlate_nt u_nt (
    .addr_i (nt_addr_i),
    .mode_i (nt_mode_i),
    .addr_o (nt_addr_o)
  );

  assign wram_en_o = ~wram_block_i;

endmodule

// File: rtl/bank_xlate_chk.sv
module bank_xlate_chk
  import bank_xlate_pkg::*;
#(
  parameter int unsigned PROG_BANK_W = 4,
  parameter int unsigned TILE_BANK_W = 5,
  localparam int unsigned CPU_W   = PROG_PAGE_BITS + 1,
  localparam int unsigned TILE_W  = TILE_PAGE_BITS + 1,
  localparam int unsigned NT_W    = NT_PAGE_BITS + 2,
  localparam int unsigned PROG_OW = PROG_PAGE_BITS + PROG_BANK_W,
  localparam int unsigned TILE_OW = TILE_PAGE_BITS + TILE_BANK_W,
  localparam int unsigned NT_OW   = NT_PAGE_BITS + 1
) (
  input logic [CPU_W-1:0]       cpu_addr_i,
  input logic [TILE_W-1:0]      tile_addr_i,
  input logic [NT_W-1:0]        nt_addr_i,
  input logic                   prog_win16_i,
  input logic                   prog_fix_last_i,
  input logic                   tile_split_i,
  input logic [1:0]             nt_mode_i,
  input logic                   wram_block_i,
  input logic [PROG_OW-1:0]     prog_addr_o,
  input logic [TILE_OW-1:0]     tile_addr_o,
  input logic [NT_OW-1:0]       nt_addr_o,
  input logic                   wram_en_o
);

  logic region_p;
  logic region_t;

  assign region_p = cpu_addr_i[PROG_PAGE_BITS];
  assign region_t = tile_addr_i[TILE_PAGE_BITS];

  always_comb begin
    assert_prog_offset_R1: assert (prog_addr_o[PROG_PAGE_BITS-1:0] == cpu_addr_i[PROG_PAGE_BITS-1:0]);
    if (!prog_win16_i)
      assert_prog_pair_region_R2: assert (prog_addr_o[PROG_PAGE_BITS] == region_p);
    if (prog_win16_i && prog_fix_last_i && region_p)
      assert_prog_last_fixed_R3: assert (&prog_addr_o[PROG_OW-1:PROG_PAGE_BITS]);
    if (prog_win16_i && !prog_fix_last_i && !region_p)
      assert_prog_first_fixed_R4: assert (prog_addr_o[PROG_OW-1:PROG_PAGE_BITS] == '0);
    assert_tile_offset_R5: assert (tile_addr_o[TILE_PAGE_BITS-1:0] == tile_addr_i[TILE_PAGE_BITS-1:0]);
    if (!tile_split_i)
      assert_tile_pair_region_R7: assert (tile_addr_o[TILE_PAGE_BITS] == region_t);
    if (nt_mode_i[1] == 1'b0)
      assert_nt_fixed_page_R8: assert (nt_addr_o[NT_PAGE_BITS] == nt_mode_i[0]);
    assert_nt_offset_R9: assert (nt_addr_o[NT_PAGE_BITS-1:0] == nt_addr_i[NT_PAGE_BITS-1:0]);
    assert_wram_en_R10: assert (wram_en_o != wram_block_i);
  end

endmodule

bind bank_xlate bank_xlate_chk #(
  .PROG_BANK_W (PROG_BANK_W),
  .TILE_BANK_W (TILE_BANK_W)
) u_chk (
  .cpu_addr_i      (cpu_addr_i),
  .tile_addr_i     (tile_addr_i),
  .nt_addr_i       (nt_addr_i),
  .prog_win16_i    (prog_win16_i),
  .prog_fix_last_i (prog_fix_last_i),
  .tile_split_i    (tile_split_i),
  .nt_mode_i       (nt_mode_i),
  .wram_block_i    (wram_block_i),
  .prog_addr_o     (prog_addr_o),
  .tile_addr_o     (tile_addr_o),
  .nt_addr_o       (nt_addr_o),
  .wram_en_o       (wram_en_o)
);

// File: tb/bank_xlate_test.sv
module bank_xlate_test;

  logic        clk;
  logic [14:0] cpu_addr;
  logic [12:0] tile_addr;
  logic [11:0] nt_addr;
  logic        win16, fix_last, split, wblock;
  logic [3:0]  pbank;
  logic [4:0]  tb0, tb1;
  logic [1:0]  ntm;
  logic [17:0] prog_out;
  logic [16:0] tile_out;
  logic [10:0] nt_out;
  logic        wen;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  bank_xlate uut (
    .cpu_addr_i      (cpu_addr),
    .tile_addr_i     (tile_addr),
    .nt_addr_i       (nt_addr),
    .prog_win16_i    (win16),
    .prog_fix_last_i (fix_last),
    .prog_bank_i     (pbank),
    .tile_split_i    (split),
    .tile_bank0_i    (tb0),
    .tile_bank1_i    (tb1),
    .nt_mode_i       (ntm),
    .wram_block_i    (wblock),
    .prog_addr_o     (prog_out),
    .tile_addr_o     (tile_out),
    .nt_addr_o       (nt_out),
    .wram_en_o       (wen)
  );

  function automatic logic [3:0] exp_prog_page();
    logic r = cpu_addr[14];
    if (!win16) return {pbank[3:1], r};
    if (fix_last) return r ? 4'hF : pbank;
    return r ? pbank : 4'h0;
  endfunction

  function automatic logic [4:0] exp_tile_page();
    logic r = tile_addr[12];
    if (split) return r ? tb1 : tb0;
    return {tb0[4:1], r};
  endfunction

  function automatic logic exp_nt_page();
    case (ntm)
      2'd0: return 1'b0;
      2'd1: return 1'b1;
      2'd2: return nt_addr[10];
      default: return nt_addr[11];
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all();
    string rp, rt, rn;
    @(negedge clk);
    rp = !win16 ? "R2" : (fix_last ? "R3" : "R4");
    rt = split ? "R6" : "R7";
    rn = ntm[1] ? "R9" : "R8";
    check("R1", 32'(prog_out[13:0]), 32'(cpu_addr[13:0]));
    check(rp,   32'(prog_out[17:14]), 32'(exp_prog_page()));
    check("R5", 32'(tile_out[11:0]), 32'(tile_addr[11:0]));
    check(rt,   32'(tile_out[16:12]), 32'(exp_tile_page()));
    check("R9", 32'(nt_out[9:0]), 32'(nt_addr[9:0]));
    check(rn,   32'(nt_out[10]), 32'(exp_nt_page()));
    check("R10", 32'(wen), 32'(!wblock));
  endtask

  task automatic drive(input logic [14:0] c, input logic [12:0] t, input logic [11:0] n,
                       input logic w16, input logic fl, input logic [3:0] pb,
                       input logic sp, input logic [4:0] b0, input logic [4:0] b1,
                       input logic [1:0] m, input logic wb);
    @(posedge clk);
    cpu_addr = c; tile_addr = t; nt_addr = n; win16 = w16; fix_last = fl;
    pbank = pb; split = sp; tb0 = b0; tb1 = b1; ntm = m; wblock = wb;
    check_all();
  endtask

  initial begin
    int seed;
    logic [16:0] keep;
    seed = $urandom(32'h5EED_1234);
    // all-zero input pattern
    drive(15'h0, 13'h0, 12'h0, 0, 0, 4'h0, 0, 5'h0, 5'h0, 2'd0, 0);
    // R2: low bank bit dropped in 32K mode, region bit takes its place
    drive(15'h4ABC, 13'h0, 12'h0, 0, 0, 4'h7, 0, 5'h0, 5'h0, 2'd0, 0);
    drive(15'h0123, 13'h0, 12'h0, 0, 1, 4'h7, 0, 5'h0, 5'h0, 2'd0, 0);
    // R3 / R4 corner regions
    drive(15'h7FFF, 13'h0, 12'h0, 1, 1, 4'h3, 0, 5'h0, 5'h0, 2'd0, 0);
    drive(15'h3FFF, 13'h0, 12'h0, 1, 1, 4'h3, 0, 5'h0, 5'h0, 2'd0, 0);
    drive(15'h0000, 13'h0, 12'h0, 1, 0, 4'h9, 0, 5'h0, 5'h0, 2'd0, 0);
    drive(15'h4000, 13'h0, 12'h0, 1, 0, 4'h9, 0, 5'h0, 5'h0, 2'd0, 0);
    // R6 / R7 tile modes; R8 / R9 mirroring; R10 block flag
    drive(15'h0, 13'h1FFF, 12'hC00, 0, 0, 4'h0, 1, 5'h0A, 5'h15, 2'd3, 1);
    drive(15'h0, 13'h0FFF, 12'h400, 0, 0, 4'h0, 1, 5'h0A, 5'h15, 2'd2, 1);
    drive(15'h0, 13'h1000, 12'hBFF, 0, 0, 4'h0, 0, 5'h1F, 5'h00, 2'd1, 0);
    // R7: tile bank 1 has no effect in paired mode
    drive(15'h0, 13'h1234, 12'h3FF, 0, 0, 4'h0, 0, 5'h0B, 5'h00, 2'd0, 0);
    keep = tile_out;
    drive(15'h0, 13'h1234, 12'h3FF, 0, 0, 4'h0, 0, 5'h0B, 5'h1F, 2'd0, 0);
    check("R7", 32'(tile_out), 32'(keep));
    for (int i = 0; i < 400; i++) begin
      drive(15'($urandom), 13'($urandom), 12'($urandom), 1'($urandom), 1'($urandom),
            4'($urandom), 1'($urandom), 5'($urandom), 5'($urandom), 2'($urandom),
            1'($urandom));
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule